// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a bus-attached system timer for a chip that has a 32768 Hz slow-clock tick. A free-running real-time counter advances through a programmable prescaler. At reset the prescaler gives one count per second. Software can set the prescaler to make the counter step on every slow-clock tick, and then use the counter as a continuous time base.

Two event sources sit next to the counter. The first is an alarm that compares against an absolute counter value. The second is a periodic interval timer that counts slow-clock ticks and fires again each time its programmed period elapses.

Four event flags are gathered in a status register that clears when it is read. A mask register, changed only through a set-only register and a clear-only register, selects which flags drive the single shared interrupt line. The slow clock appears as a one-cycle tick enable in the bus clock domain, so a counter read between two ticks always returns the same settled value.

Top module: `slowclk_sys_timer`

## Requirements
- R1: After reset the registers read as follows: counter 0, status 0, mask 0, period 0, watchdog mode 0, alarm all ones, prescaler 32768 (PRE_RST). The interrupt output is low.
- R2: With the reset prescaler, the counter advances by one after each 32768 slow-clock ticks and holds its value between advances.
- R3: A write of N to the prescaler (offset 0x08) restarts the prescale count. The counter then advances once every N ticks; N = 1 advances it on every tick, and N = 0 acts as 2^PRE_W.
- R4: The counter is CNT_W bits wide and wraps from all ones to zero without stopping. Every advance sets the counter-increment flag, status bit 2.
- R5: The alarm flag, status bit 3, sets when the counter steps to a value equal to the alarm register (offset 0x1C). If the alarm is loaded with the value the counter already holds, the flag stays clear until the counter has made a full 2^CNT_W steps.
- R6: A write of P to the period register (offset 0x00) restarts the interval timer. The interval flag, status bit 0, then sets on the P-th tick after the write and again every P ticks. P = 0 stops it.
- R7: A read of the status register (offset 0x0C) returns the flags and clears them all. A flag whose event happens in the same cycle as the read stays set.
- R8: Writing ones to offset 0x10 sets the corresponding mask bits. Writing ones to offset 0x14 clears them. Bits written as zero are unchanged, and the mask reads back at offset 0x18.
- R9: The interrupt output is high exactly when some status flag is set and its mask bit is set.
- R10: The watchdog-overflow flag, status bit 1, never sets. The watchdog mode register (offset 0x04) holds the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow-clock tick enable |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| irq | output | 1 | Shared interrupt line |

## Verification
The bench keeps the prescaler width and the reset value at 32768, so the one-per-second reset rate is observed over a full 32768-tick window. It narrows the counter to CNT_W = 8. That brings the wrap from all ones to zero, and the full-wrap delay of an alarm loaded with the current count, within a few hundred ticks. The tick is driven one bus cycle at a time, so a status read can be placed in the very cycle of a counter step.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int FLG_N = 4;
  localparam int F_PIT  = 0;
  localparam int F_WDOG = 1;
  localparam int F_INC  = 2;
  localparam int F_ALM  = 3;

  localparam int A_PERIOD = 'h00;
  localparam int A_WDMODE = 'h04;
  localparam int A_PRESC  = 'h08;
  localparam int A_STATUS = 'h0C;
  localparam int A_IEN    = 'h10;
  localparam int A_IDIS   = 'h14;
  localparam int A_MASK   = 'h18;
  localparam int A_ALARM  = 'h1C;
  localparam int A_COUNT  = 'h20;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             alm_wr,
  input  logic [CNT_W-1:0] alm_wdata,
  output logic [PRE_W-1:0] pre_q,
  output logic [CNT_W-1:0] alm_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inc_ev,
  output logic             alm_ev
);
  // Number of ticks per count; a zero setting means the full range.
  function automatic logic [PRE_W:0] roll_limit(input logic [PRE_W-1:0] v);
    return (v == '0) ? {1'b1, {PRE_W{1'b0}}} : {1'b0, v};
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   pre_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  assign pre_nxt = {1'b0, pre_cnt} + 1'b1;
  assign inc_ev  = tick && !pre_wr && (pre_nxt == roll_limit(pre_q));
  assign cnt_nxt = step(cnt_q);
  assign alm_ev  = inc_ev && (cnt_nxt == alm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= PRE_W'(PRE_RST);
      pre_cnt <= '0;
      cnt_q   <= '0;
      alm_q   <= '1;
    end else begin
      if (pre_wr) begin
        pre_q   <= pre_wdata;
        pre_cnt <= '0;
      end else if (inc_ev) begin
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= pre_nxt[PRE_W-1:0];
      end
      if (inc_ev) cnt_q <= cnt_nxt;
      if (alm_wr) alm_q <= alm_wdata;
    end
  end
endmodule

// File: rtl/st_pit.sv
module st_pit #(
  parameter int PIT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             per_wr,
  input  logic [PIT_W-1:0] per_wdata,
  output logic [PIT_W-1:0] per_q,
  output logic             pit_ev
);
  logic [PIT_W-1:0] down_q;

  // The period expires on the tick that finds one count or fewer left.
  function automatic logic expired(input logic [PIT_W-1:0] left);
    return left <= PIT_W'(1);
  endfunction

  assign pit_ev = tick && !per_wr && (per_q != '0) && expired(down_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      down_q <= '0;
    end else if (per_wr) begin
      per_q  <= per_wdata;
      down_q <= per_wdata;
    end else if (pit_ev) begin
      down_q <= per_q;
    end else if (tick && per_q != '0) begin
      down_q <= down_q - 1'b1;
    end
  end
endmodule

// File: rtl/st_flags.sv
module st_flags #(
  parameter int FLG_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] ev,
  input  logic             clr_rd,
  input  logic             ien_wr,
  input  logic             idis_wr,
  input  logic [FLG_N-1:0] wbits,
  output logic [FLG_N-1:0] sts_q,
  output logic [FLG_N-1:0] mask_q,
  output logic             irq
);
  // New events override the clear done by a status read.
  function automatic logic [FLG_N-1:0] next_flags(input logic [FLG_N-1:0] cur,
                                                  input logic clr,
                                                  input logic [FLG_N-1:0] e);
    return (clr ? '0 : cur) | e;
  endfunction

  assign irq = |(sts_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q <= next_flags(sts_q, clr_rd, ev);
      if (ien_wr)       mask_q <= mask_q | wbits;
      else if (idis_wr) mask_q <= mask_q & ~wbits;
    end
  end
endmodule

// File: rtl/slowclk_sys_timer.sv
module slowclk_sys_timer
  import st_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int PIT_W   = 16,
  parameter int WD_W    = 16,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic wr, rd;
  logic pre_wr, alm_wr, per_wr, wd_wr, ien_wr, idis_wr, rd_sts;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] alm_q, cnt_q;
  logic [PIT_W-1:0] per_q;
  logic [WD_W-1:0]  wd_q;
  logic inc_ev, alm_ev, pit_ev;
  logic [FLG_N-1:0] ev, sts_q, mask_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign pre_wr  = wr && hit(bus_addr, A_PRESC);
  assign alm_wr  = wr && hit(bus_addr, A_ALARM);
  assign per_wr  = wr && hit(bus_addr, A_PERIOD);
  assign wd_wr   = wr && hit(bus_addr, A_WDMODE);
  assign ien_wr  = wr && hit(bus_addr, A_IEN);
  assign idis_wr = wr && hit(bus_addr, A_IDIS);
  assign rd_sts  = rd && hit(bus_addr, A_STATUS);

  st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pre_wr(pre_wr), .pre_wdata(bus_wdata[PRE_W-1:0]),
    .alm_wr(alm_wr), .alm_wdata(bus_wdata[CNT_W-1:0]),
    .pre_q(pre_q), .alm_q(alm_q), .cnt_q(cnt_q),
    .inc_ev(inc_ev), .alm_ev(alm_ev)
  );

  st_pit #(.PIT_W(PIT_W)) u_pit (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .per_wr(per_wr), .per_wdata(bus_wdata[PIT_W-1:0]),
    .per_q(per_q), .pit_ev(pit_ev)
  );

  always_comb begin
    ev         = '0;
    ev[F_PIT]  = pit_ev;
    ev[F_INC]  = inc_ev;
    ev[F_ALM]  = alm_ev;
  end

  st_flags #(.FLG_N(FLG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr_rd(rd_sts),
    .ien_wr(ien_wr), .idis_wr(idis_wr), .wbits(bus_wdata[FLG_N-1:0]),
    .sts_q(sts_q), .mask_q(mask_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_wr) wd_q <= bus_wdata[WD_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if      (hit(bus_addr, A_PERIOD)) bus_rdata = DATA_W'(per_q);
      else if (hit(bus_addr, A_WDMODE)) bus_rdata = DATA_W'(wd_q);
      else if (hit(bus_addr, A_PRESC))  bus_rdata = DATA_W'(pre_q);
      else if (hit(bus_addr, A_STATUS)) bus_rdata = DATA_W'(sts_q);
      else if (hit(bus_addr, A_MASK))   bus_rdata = DATA_W'(mask_q);
      else if (hit(bus_addr, A_ALARM))  bus_rdata = DATA_W'(alm_q);
      else if (hit(bus_addr, A_COUNT))  bus_rdata = DATA_W'(cnt_q);
    end
  end
endmodule

// File: rtl/st_timer_chk.sv
module st_timer_chk
  import st_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  alm_q,
  input logic              inc_ev,
  input logic              alm_ev,
  input logic              pit_ev,
  input logic              rd_sts,
  input logic [FLG_N-1:0]  ev,
  input logic [FLG_N-1:0]  sts_q,
  input logic [FLG_N-1:0]  mask_q
);
  logic set_w, clr_w;
  assign set_w = bus_sel && bus_we && bus_addr == ADDR_W'(A_IEN);
  assign clr_w = bus_sel && bus_we && bus_addr == ADDR_W'(A_IDIS);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_ev |=> $stable(cnt_q));
  a_r3_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |-> tick);
  a_r5_match: assert property (@(posedge clk) disable iff (!rst_n)
    alm_ev |=> cnt_q == $past(alm_q));
  a_r5_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    alm_ev |-> inc_ev);
  a_r6_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pit_ev |-> tick);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && ev == '0) |=> sts_q == '0);
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> (sts_q & $past(ev)) == $past(ev));
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> (mask_q & $past(bus_wdata[FLG_N-1:0])) == $past(bus_wdata[FLG_N-1:0]));
  a_r8_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (mask_q & $past(bus_wdata[FLG_N-1:0])) == '0);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind slowclk_sys_timer st_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/slowclk_sys_timer_test.sv
module slowclk_sys_timer_test;
  localparam int CNT_W = 8;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_we = 0, irq;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  slowclk_sys_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic drive(input logic sel, input logic we, input int a,
                       input logic [DW-1:0] d, input logic t);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = AW'(a); bus_wdata = d; tick = t;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    drive(1, 1, a, d, 0);
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string tg, input logic t = 0);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    drive(1, 0, a, '0, t);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, '0, 1);
  endtask

  task automatic chk_irq(input logic e, input string tg);
    drive(0, 0, 0, '0, 0);
    #2;
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual %0b expected %0b", tg, irq, e);
    end
  endtask

  // Monitor: compares every read against the next queued expectation.
  always @(negedge clk) begin
    #2;
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", tg, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd('h20, 0, "R1 count");
    rd('h0C, 0, "R1 status");
    rd('h18, 0, "R1 mask");
    rd('h00, 0, "R1 period");
    rd('h04, 0, "R1 wdmode");
    rd('h1C, 'hFF, "R1 alarm");
    rd('h08, 32768, "R1 prescaler");
    chk_irq(0, "R1 irq");
    // R2 one count per 32768 ticks
    ticks(32767);
    rd('h20, 0, "R2 before rollover");
    ticks(1);
    rd('h20, 1, "R2 after rollover");
    rd('h20, 1, "R2 stable");
    rd('h0C, 4, "R4 increment flag");
    rd('h0C, 0, "R7 cleared by read");
    // R3 prescaler
    wr('h08, 3);
    ticks(2);
    rd('h20, 1, "R3 two of three ticks");
    ticks(1);
    rd('h20, 2, "R3 third tick");
    wr('h08, 1);
    ticks(5);
    rd('h20, 7, "R3 every tick");
    rd('h0C, 4, "R3 status");
    // R4 wrap, alarm at all ones
    ticks(248);
    rd('h20, 255, "R4 at all ones");
    rd('h0C, 'hC, "R5 alarm at 0xFF");
    ticks(1);
    rd('h20, 0, "R4 wrapped");
    rd('h0C, 4, "R4 wrap status");
    // R5 alarm loaded with current count
    wr('h1C, 0);
    ticks(255);
    rd('h0C, 4, "R5 no early alarm");
    ticks(1);
    rd('h0C, 'hC, "R5 alarm after full wrap");
    wr('h1C, 5);
    ticks(4);
    rd('h0C, 4, "R5 before match");
    ticks(1);
    rd('h0C, 'hC, "R5 at match");
    // R8 / R9 masking
    ticks(1);
    chk_irq(0, "R9 masked");
    wr('h10, 4);
    rd('h18, 4, "R8 set");
    chk_irq(1, "R9 enabled");
    wr('h14, 4);
    rd('h18, 0, "R8 clear");
    chk_irq(0, "R9 disabled");
    wr('h10, 'hF);
    rd('h18, 'hF, "R8 set all");
    chk_irq(1, "R9 all enabled");
    rd('h0C, 4, "R7 read status");
    chk_irq(0, "R9 after clear");
    wr('h14, 'hA);
    rd('h18, 5, "R8 partial clear");
    wr('h14, 'hF);
    // R6 periodic timer
    wr('h00, 3);
    rd('h00, 3, "R6 period readback");
    ticks(2);
    rd('h0C, 4, "R6 not yet");
    ticks(1);
    rd('h0C, 5, "R6 first period");
    ticks(3);
    rd('h0C, 5, "R6 repeat");
    ticks(2);
    wr('h00, 4);
    ticks(3);
    rd('h0C, 4, "R6 restart pending");
    ticks(1);
    rd('h0C, 5, "R6 after restart");
    wr('h00, 0);
    ticks(10);
    rd('h0C, 4, "R6 disabled");
    // R7 event in the cycle of a status read survives
    rd('h0C, 0, "R7 read with tick", 1);
    rd('h0C, 4, "R7 event kept");
    // R10 watchdog mode register
    wr('h04, 'h1234);
    rd('h04, 'h1234, "R10 wdmode");
    rd('h0C, 0, "R10 no watchdog flag");
    drive(0, 0, 0, '0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule